// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Unit

This block collects one-cycle event pulses from the receive path, transmit path, link monitor and bus error detector of a network controller, plus two internal sources: a free-running timer with a compare register, and a software strobe written through a poll register. Each pulse latches a bit in a 16-bit pending register. A 16-bit enable register with the same bit layout gates the pending bits onto one level-sensitive interrupt line.

Software reads the pending register to find what happened and writes 1s back to acknowledge exactly those bits. It can silence the line at once by writing 0 to the enable register. It can program a timer interrupt by loading a nonzero compare value and writing the count register, which restarts the count from zero.

The register port uses 16-bit data and byte addresses; address bit 0 is ignored. The map is: poll 0x00, enable 0x04, pending 0x06, count low 0x08, count high 0x0A, compare low 0x0C, compare high 0x0E. The enable register sits 2 bytes below the pending register.

Top module: `isr_unit`

## Requirements
- R1: After reset the pending register, enable register, timer count and compare value are all 0, and irq_o is low.
- R2: An event pulse on evt_i sets its pending bit at the next clock edge. The bit map is: 0 rx ok, 1 rx error, 2 tx ok, 3 tx error, 4 rx descriptor unavailable, 5 underrun or link change, 6 rx FIFO overflow, 7 tx descriptor unavailable, 15 system error. Set bits accumulate until cleared.
- R3: A write to the pending register (0x06) clears exactly the bits written as 1 and leaves all other bits unchanged. Writing 0xFFFF clears every pending bit.
- R4: If an event pulse and a write-1-to-clear hit the same bit in the same cycle, the bit stays set.
- R5: irq_o is high whenever (pending AND enable) is nonzero. It stays high until the contributing bits are cleared or disabled.
- R6: The enable register (0x04) reads back what was written on implemented bits. Writing 0 to it drives irq_o low at the next edge.
- R7: Bits 9 to 13 of the pending and enable registers always read 0 and ignore writes. evt_i bits 8 to 14 have no effect.
- R8: Writing a value with bit 0 set to the poll register (0x00) sets pending bit 8 (software). Other poll bits have no effect, and the poll register reads as 0.
- R9: The 32-bit timer count increments on every clock. Any write to either count half (0x08, 0x0A) sets the count to 0 at that edge. A read returns the count value held before the read edge.
- R10: When the compare value (0x0C low, 0x0E high) is nonzero and the count equals it, pending bit 14 is set at the next edge. A compare value of 0 disables the timer event.
- R11: A read returns its data on rdata_o one cycle after rd_i. Unmapped addresses read as 0. rdata_o holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid one cycle after rd_i |
| evt_i | input | 16 | Event pulses from the source blocks, in pending-bit positions |
| irq_o | output | 1 | Level interrupt output |

## Verification
The hardest case to reach is the same-cycle collision between a new event and an acknowledge write on the same bit. The stimulus drives the evt_i pulse and the pending-register write on one falling edge, so both are sampled at the same rising edge. The same write also clears a second, non-colliding bit, which shows that only the colliding bit survives.

The timer event is hard to reach because the count runs freely. The stimulus first loads the compare value and then writes the count to zero, which fixes the cycle of the match. It then reads the pending register a few cycles before and after that cycle.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned DATA_W = 16;

  // byte offsets; enable sits 2 below pending
  localparam logic [7:0] OFF_POLL   = 8'h00;
  localparam logic [7:0] OFF_ENA    = 8'h04;
  localparam logic [7:0] OFF_PEND   = 8'h06;
  localparam logic [7:0] OFF_CNT_LO = 8'h08;
  localparam logic [7:0] OFF_CNT_HI = 8'h0A;
  localparam logic [7:0] OFF_CMP_LO = 8'h0C;
  localparam logic [7:0] OFF_CMP_HI = 8'h0E;

  localparam int unsigned BIT_SWI = 8;
  localparam int unsigned BIT_TMR = 14;

  localparam logic [DATA_W-1:0] IMPL_BITS = 16'hC1FF;
  localparam logic [DATA_W-1:0] EXT_BITS  = 16'h80FF;

  typedef struct packed {
    logic poll;
    logic ena;
    logic pend;
    logic cnt_lo;
    logic cnt_hi;
    logic cmp_lo;
    logic cmp_hi;
  } reg_sel_t;
endpackage

// File: rtl/isr_decode.sv
module isr_decode
  import isr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  localparam int unsigned WA_W = ADDR_W - 1;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a[ADDR_W-1:1] == WA_W'(off[7:1]);
  endfunction

  always_comb begin
    sel_o.poll   = hit(addr_i, OFF_POLL);
    sel_o.ena    = hit(addr_i, OFF_ENA);
    sel_o.pend   = hit(addr_i, OFF_PEND);
    sel_o.cnt_lo = hit(addr_i, OFF_CNT_LO);
    sel_o.cnt_hi = hit(addr_i, OFF_CNT_HI);
    sel_o.cmp_lo = hit(addr_i, OFF_CMP_LO);
    sel_o.cmp_hi = hit(addr_i, OFF_CMP_HI);
  end
endmodule

// File: rtl/isr_status.sv
module isr_status
  import isr_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter logic [W-1:0] IMPL = IMPL_BITS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic         ena_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] ena_o,
  output logic         irq_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_o[i] <= 1'b0;
          ena_o[i]  <= 1'b0;
        end else begin
          // new event wins over acknowledge
          pend_o[i] <= set_i[i] | (pend_o[i] & ~(clr_wr_i & wdata_i[i]));
          if (ena_wr_i) ena_o[i] <= wdata_i[i];
        end
      end
    end else begin : g_none
      assign pend_o[i] = 1'b0;
      assign ena_o[i]  = 1'b0;
    end
  end

  assign irq_o = |(pend_o & ena_o);

  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & IMPL) != '0) |=> ((pend_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  a_r3_clear_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((pend_o & $past(wdata_i & ~set_i)) == '0));

  a_r6_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_wr_i && wdata_i == '0) |=> !irq_o);
endmodule

// File: rtl/isr_timer.sv
module isr_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_wr_i,
  input  logic             cmp_lo_wr_i,
  input  logic             cmp_hi_wr_i,
  input  logic [15:0]      wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);
  localparam int unsigned HI_W = CNT_W - 16;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      cmp_o <= '0;
    end else begin
      cnt_o <= cnt_wr_i ? '0 : cnt_o + 1'b1;
      if (cmp_lo_wr_i) cmp_o[15:0]      <= wdata_i;
      if (cmp_hi_wr_i) cmp_o[CNT_W-1:16] <= wdata_i[HI_W-1:0];
    end
  end

  assign hit_o = (cmp_o != '0) && (cnt_o == cmp_o);

  a_r9_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_o == '0));

  a_r9_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));
endmodule

// File: rtl/isr_unit.sv
module isr_unit
  import isr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic [15:0]       evt_i,
  output logic              irq_o
);
  localparam int unsigned HI_W = CNT_W - 16;

  reg_sel_t         sel;
  logic [15:0]      pend, ena, set_vec, rd_mux;
  logic [CNT_W-1:0] cnt, cmp;
  logic             tmr_hit, swi;

  isr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr_i(addr_i), .sel_o(sel));

  assign swi = wr_i & sel.poll & wdata_i[0];

  always_comb begin
    set_vec          = evt_i & EXT_BITS;
    set_vec[BIT_SWI] = swi;
    set_vec[BIT_TMR] = tmr_hit;
  end

  isr_status u_stat (
    .clk_i, .rst_ni,
    .set_i    (set_vec),
    .clr_wr_i (wr_i & sel.pend),
    .ena_wr_i (wr_i & sel.ena),
    .wdata_i  (wdata_i),
    .pend_o   (pend),
    .ena_o    (ena),
    .irq_o    (irq_o)
  );

  isr_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .cnt_wr_i    (wr_i & (sel.cnt_lo | sel.cnt_hi)),
    .cmp_lo_wr_i (wr_i & sel.cmp_lo),
    .cmp_hi_wr_i (wr_i & sel.cmp_hi),
    .wdata_i     (wdata_i),
    .cnt_o       (cnt),
    .cmp_o       (cmp),
    .hit_o       (tmr_hit)
  );

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel.ena:    rd_mux = ena;
      sel.pend:   rd_mux = pend;
      sel.cnt_lo: rd_mux = cnt[15:0];
      sel.cnt_hi: rd_mux = 16'(cnt[CNT_W-1:16]);
      sel.cmp_lo: rd_mux = cmp[15:0];
      sel.cmp_hi: rd_mux = 16'(cmp[CNT_W-1:16]);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  a_r8_poll_sets_swi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel.poll && wdata_i[0]) |=> pend[BIT_SWI]);

  a_r10_timer_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_hit |=> pend[BIT_TMR]);

  a_r7_unused_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (sel.pend || sel.ena)) |=> (rdata_o[13:9] == 5'b0));

  a_r11_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/sim_isr_unit.sv
module sim_isr_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, evt = '0;
  logic [15:0] rdata;
  logic        irq;

  always #4 clk = ~clk;

  isr_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  int errs = 0, checks = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  logic [15:0] care_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd;

  // monitor: compare read data the cycle after each read
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [15:0] e, c;
      string t;
      e = exp_q.pop_front();
      c = care_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {16'h0, rdata & c}, {16'h0, e & c});
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, logic [15:0] e, string t, logic [15:0] c = 16'hFFFF);
    exp_q.push_back(e); care_q.push_back(c); tag_q.push_back(t);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse(logic [15:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    rd_reg(8'h06, 16'h0000, "R1 pending reset");
    rd_reg(8'h04, 16'h0000, "R1 enable reset");
    rd_reg(8'h0C, 16'h0000, "R1 compare reset");

    // R6 / R7 enable layout
    wr_reg(8'h04, 16'hFFFF);
    rd_reg(8'h04, 16'hC1FF, "R6 R7 enable readback");
    wr_reg(8'h04, 16'h0000);

    // R2 all external events
    pulse(16'h80FF);
    rd_reg(8'h06, 16'h80FF, "R2 all events");
    wr_reg(8'h06, 16'hFFFF);
    rd_reg(8'h06, 16'h0000, "R3 clear all");
    pulse(16'h7F00);
    rd_reg(8'h06, 16'h0000, "R7 ignored event bits");
    wr_reg(8'h06, 16'h3E00);
    rd_reg(8'h06, 16'h0000, "R7 unused bit writes");

    pulse(16'h0005);
    rd_reg(8'h06, 16'h0005, "R2 pattern a");
    pulse(16'h8040);
    rd_reg(8'h06, 16'h8045, "R2 accumulate");
    wr_reg(8'h06, 16'h0041);
    rd_reg(8'h06, 16'h8004, "R3 exact clear");

    // R5 / R6 level irq
    chk("R5 masked off", {31'h0, irq}, 32'h0);
    wr_reg(8'h04, 16'h0004);
    chk("R5 irq enabled", {31'h0, irq}, 32'h1);
    idle(3);
    chk("R5 irq level held", {31'h0, irq}, 32'h1);
    wr_reg(8'h04, 16'h0000);
    chk("R6 disable drops irq", {31'h0, irq}, 32'h0);
    wr_reg(8'h04, 16'h8000);
    chk("R5 irq via bit 15", {31'h0, irq}, 32'h1);
    wr_reg(8'h06, 16'h8000);
    chk("R5 irq after ack", {31'h0, irq}, 32'h0);
    rd_reg(8'h06, 16'h0004, "R5 other bit kept");

    // R4 collision
    wr_reg(8'h06, 16'hFFFF);
    pulse(16'h0002);
    evt = 16'h0001; addr = 8'h06; wdata = 16'h0003; wr = 1'b1;
    @(negedge clk);
    evt = '0; wr = 1'b0;
    rd_reg(8'h06, 16'h0001, "R4 event beats clear");

    // R8 software strobe
    wr_reg(8'h06, 16'hFFFF);
    wr_reg(8'h00, 16'h00FE);
    rd_reg(8'h06, 16'h0000, "R8 other poll bits");
    wr_reg(8'h00, 16'h0001);
    rd_reg(8'h06, 16'h0100, "R8 software bit");
    rd_reg(8'h00, 16'h0000, "R8 poll reads zero");

    // R9 timer count
    wr_reg(8'h08, 16'h5555);
    rd_reg(8'h08, 16'h0000, "R9 count restart");
    idle(4);
    rd_reg(8'h08, 16'h0005, "R9 count increments");
    rd_reg(8'h0A, 16'h0000, "R9 count high");
    wr_reg(8'h0A, 16'h1234);
    rd_reg(8'h08, 16'h0000, "R9 high write restarts");

    // R10 timer compare
    wr_reg(8'h0C, 16'h000A);
    rd_reg(8'h0C, 16'h000A, "R11 compare readback");
    wr_reg(8'h06, 16'hFFFF);
    wr_reg(8'h08, 16'h0000);
    idle(7);
    rd_reg(8'h06, 16'h0000, "R10 before match", 16'h4000);
    idle(5);
    rd_reg(8'h06, 16'h4000, "R10 after match", 16'h4000);
    wr_reg(8'h0C, 16'h0000);
    wr_reg(8'h06, 16'hFFFF);
    wr_reg(8'h08, 16'h0000);
    idle(20);
    rd_reg(8'h06, 16'h0000, "R10 zero compare disables");

    // R11 unmapped and hold
    rd_reg(8'h02, 16'h0000, "R11 unmapped read");
    idle(2);
    chk("R11 read data held", {16'h0, rdata}, 32'h0);
    idle(2);
    finish_run();
  end
endmodule